// File: doc/BRIEF.md
# Link Bring-Up Stage Monitor

This block follows the bring-up of a serial link as a visible sequence of stages. An external physical-layer training engine supplies status strobes (lane present, training complete, equalization converged, lock achieved, error request). The monitor moves through the stages in a fixed order, bounds the time spent in each one, and keeps a budget of training retries. It also counts retries, retrain passes and recovery entries, and logs every stage change as a timestamped event word. It never touches the link itself. It only sequences and observes.

The states and their codes are: Reset, Detect, Train, Equalize, Lock, Stable, Recovery and Failed. The transitions are:

- Reset to Detect when bring-up is enabled.
- Detect to Train after lane presence has been held steady.
- Train to Equalize on training done.
- Equalize to Lock on converged.
- Lock to Stable on lock.
- Stable to Recovery on an error request.
- Recovery back to Stable on relock.
- The retry path: a stage timeout re-enters Detect, or goes to Failed once the budget is spent.
- The retrain gate: a Recovery timeout goes to Detect and is counted on its own.
- A software reset sends any state to Reset.

Each transition pushes a word holding the entered state and a free-running timestamp into a small event queue. Software drains that queue.

Top module: `link_train_monitor`

## Requirements
- R1: While rst_n is low, and afterwards, the monitor sits in Reset (code 0) with link_ready, bringup_failed, all counters, evt_valid and evt_overflow at 0. It stays in Reset until bringup_en is sampled high, then enters Detect on the next clock.
- R2: State codes on state_o are Reset=0, Detect=1, Train=2, Equalize=3, Lock=4, Stable=5, Recovery=6, Failed=7. Train advances on train_done, Equalize on eq_done and Lock on lock_ok. A strobe that belongs to another stage has no effect. link_ready is high exactly while in Stable.
- R3: Detect advances to Train only in the cycle where lane_detect has been high for cfg_debounce consecutive cycles, counting that cycle. Any low cycle restarts the count.
- R4: The stage limit is cfg_detect_tmo in Detect, cfg_train_tmo in Train, and cfg_stage_tmo in Equalize, Lock and Recovery. A stage whose exit condition is not seen stays exactly limit cycles and then times out. An exit condition in the last cycle wins over the timeout. A limit of 0 disables that timeout.
- R5: A timeout in Detect, Train, Equalize or Lock increments retry_cnt and re-enters Detect.
- R6: When a timeout from R5 occurs with retry_cnt already at or above cfg_retry_limit, the monitor still increments retry_cnt but enters Failed instead. bringup_failed is then high, and Failed holds under any strobe until sw_reset.
- R7: err_req in Stable enters Recovery and increments recov_cnt. err_req in any other state has no effect.
- R8: In Recovery, lock_ok returns to Stable. A Recovery timeout passes the retrain gate: it enters Detect and increments retrain_cnt, leaving retry_cnt unchanged.
- R9: All three counters saturate at 2^CNT_W-1. cnt_clear zeroes them and evt_overflow. sw_reset does not clear them.
- R10: Every transition, including a Detect re-entry after a timeout, pushes one event. The event carries the entered state's code in evt_state and the free-running cycle timestamp of the transition in evt_time, so consecutive timestamps differ by the cycles spent in the stage.
- R11: Events leave in arrival order. evt_valid is high while any is queued, and evt_pop removes the head. The queue holds FIFO_DEPTH words. An event arriving while the queue is full without a pop is dropped and sets the sticky evt_overflow.
- R12: sw_reset sends the monitor to Reset on the next clock from any state, overriding every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Software reset pulse, forces Reset |
| cnt_clear | input | 1 | Clears counters and overflow flag |
| bringup_en | input | 1 | Allows leaving Reset |
| lane_detect | input | 1 | Lane presence level |
| train_done | input | 1 | Training complete strobe |
| eq_done | input | 1 | Equalization converged strobe |
| lock_ok | input | 1 | Lock achieved strobe |
| err_req | input | 1 | Error or recovery request |
| cfg_detect_tmo | input | TMO_W | Detect stage limit in cycles |
| cfg_train_tmo | input | TMO_W | Train stage limit in cycles |
| cfg_stage_tmo | input | TMO_W | Equalize, Lock and Recovery limit |
| cfg_debounce | input | DEB_W | Required stable presence cycles |
| cfg_retry_limit | input | CNT_W | Retry budget |
| state_o | output | 3 | Current state code |
| link_ready | output | 1 | High in Stable |
| bringup_failed | output | 1 | High in Failed |
| retry_cnt | output | CNT_W | Training retries |
| retrain_cnt | output | CNT_W | Retrain gate passes |
| recov_cnt | output | CNT_W | Recovery entries |
| evt_pop | input | 1 | Removes the head event |
| evt_valid | output | 1 | An event is queued |
| evt_state | output | 3 | Head event state code |
| evt_time | output | TS_W | Head event timestamp |
| evt_overflow | output | 1 | Sticky event drop flag |

## Verification
On every cycle, the assertions enforce the following:

- sw_reset wins over every strobe.
- Failed holds.
- A low presence sample never leads straight into Train.
- Stable is reached only from Lock or Recovery.
- The recovery and retrain counts move only from Stable and Recovery.
- Every state change leaves an event queued.
- A dropped event raises the overflow flag.
- Saturated counters stay put.

Only the bench scenarios can show the cycle-exact lengths of the timeouts, the exact retry count at which bring-up fails, the order and timestamp spacing of logged events, and the way debounce restarts when presence drops for one cycle.

// File: rtl/lt_pkg.sv
package lt_pkg;
    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_DETECT = 3'd1,
        ST_TRAIN  = 3'd2,
        ST_EQ     = 3'd3,
        ST_LOCK   = 3'd4,
        ST_STABLE = 3'd5,
        ST_RECOV  = 3'd6,
        ST_FAILED = 3'd7
    } lt_state_e;
endpackage

// File: rtl/lt_sat_counter.sv
module lt_sat_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] MAX_C = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  q <= '0;
        else if (clr)                q <= '0;
        else if (inc && q != MAX_C)  q <= q + W'(1);
    end

    // R9: saturation holds, clear empties
    assert_sat_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q == MAX_C && !clr) |=> q == MAX_C);
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> q == '0);
endmodule

// File: rtl/lt_debounce.sv
module lt_debounce #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         din,
    input  logic [W-1:0] cfg_len,
    output logic         ok
);
    localparam logic [W-1:0] MAX_C = {W{1'b1}};
    logic [W-1:0] run_q;

    // run_q counts earlier consecutive high samples; this cycle adds one
    assign ok = din && (({1'b0, run_q} + (W+1)'(1)) >= {1'b0, cfg_len});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               run_q <= '0;
        else if (restart || !din) run_q <= '0;
        else if (run_q != MAX_C)  run_q <= run_q + W'(1);
    end
endmodule

// File: rtl/lt_event_fifo.sv
module lt_event_fifo #(
    parameter int DW    = 19,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_ovf,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic          valid,
    output logic [DW-1:0] dout,
    output logic          ovf
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   FULL_C = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_C = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [AW:0]   cnt_q;
    logic          full, do_push, do_pop;

    assign full    = (cnt_q == FULL_C);
    assign valid   = (cnt_q != '0);
    assign do_pop  = pop && valid;
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
            ovf   <= 1'b0;
        end else begin
            if (do_push) wr_q <= (wr_q == LAST_C) ? '0 : wr_q + AW'(1);
            if (do_pop)  rd_q <= (rd_q == LAST_C) ? '0 : rd_q + AW'(1);
            cnt_q <= cnt_q + (AW+1)'(do_push) - (AW+1)'(do_pop);
            if (clr_ovf)               ovf <= 1'b0;
            else if (push && !do_push) ovf <= 1'b1;
        end
    end

    // R11: queue never exceeds depth, a drop is flagged
    assert_fifo_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_C);
    assert_drop_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr_ovf) |=> ovf);
endmodule

// File: rtl/link_train_monitor.sv
module link_train_monitor
    import lt_pkg::*;
#(
    parameter int TS_W       = 16,
    parameter int CNT_W      = 8,
    parameter int TMO_W      = 16,
    parameter int DEB_W      = 8,
    parameter int FIFO_DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_reset,
    input  logic             cnt_clear,
    input  logic             bringup_en,
    input  logic             lane_detect,
    input  logic             train_done,
    input  logic             eq_done,
    input  logic             lock_ok,
    input  logic             err_req,
    input  logic [TMO_W-1:0] cfg_detect_tmo,
    input  logic [TMO_W-1:0] cfg_train_tmo,
    input  logic [TMO_W-1:0] cfg_stage_tmo,
    input  logic [DEB_W-1:0] cfg_debounce,
    input  logic [CNT_W-1:0] cfg_retry_limit,
    output logic [2:0]       state_o,
    output logic             link_ready,
    output logic             bringup_failed,
    output logic [CNT_W-1:0] retry_cnt,
    output logic [CNT_W-1:0] retrain_cnt,
    output logic [CNT_W-1:0] recov_cnt,
    input  logic             evt_pop,
    output logic             evt_valid,
    output logic [2:0]       evt_state,
    output logic [TS_W-1:0]  evt_time,
    output logic             evt_overflow
);
    localparam int EVT_W    = 3 + TS_W;
    localparam int N_CNT    = 3;
    localparam int CI_RETRY = 0;
    localparam int CI_RETRN = 1;
    localparam int CI_RECOV = 2;

    lt_state_e        state_q, state_d;
    logic             xfer, take_retry, deb_ok, stage_tmo_hit;
    logic [TMO_W-1:0] tmr_q, tmo_sel;
    logic [TS_W-1:0]  ts_q;
    logic [N_CNT-1:0] inc_vec;
    logic [CNT_W-1:0] cnt_arr [N_CNT];
    logic [EVT_W-1:0] evt_word;

    // per-stage limit select and timeout detection
    always_comb begin
        unique case (state_q)
            ST_DETECT:                 tmo_sel = cfg_detect_tmo;
            ST_TRAIN:                  tmo_sel = cfg_train_tmo;
            ST_EQ, ST_LOCK, ST_RECOV:  tmo_sel = cfg_stage_tmo;
            default:                   tmo_sel = '0;
        endcase
    end
    assign stage_tmo_hit = (tmo_sel != '0) &&
        (({1'b0, tmr_q} + (TMO_W+1)'(1)) == {1'b0, tmo_sel});

    lt_debounce #(.W(DEB_W)) u_presence (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q != ST_DETECT || xfer),
        .din     (lane_detect),
        .cfg_len (cfg_debounce),
        .ok      (deb_ok)
    );

    // next-state and counting decisions
    always_comb begin
        state_d    = state_q;
        xfer       = 1'b0;
        take_retry = 1'b0;
        inc_vec    = '0;
        if (sw_reset) begin
            state_d = ST_RESET;
            xfer    = (state_q != ST_RESET);
        end else begin
            unique case (state_q)
                ST_RESET:  if (bringup_en) begin state_d = ST_DETECT; xfer = 1'b1; end
                ST_DETECT: if (deb_ok)     begin state_d = ST_TRAIN;  xfer = 1'b1; end
                           else if (stage_tmo_hit) take_retry = 1'b1;
                ST_TRAIN:  if (train_done) begin state_d = ST_EQ;     xfer = 1'b1; end
                           else if (stage_tmo_hit) take_retry = 1'b1;
                ST_EQ:     if (eq_done)    begin state_d = ST_LOCK;   xfer = 1'b1; end
                           else if (stage_tmo_hit) take_retry = 1'b1;
                ST_LOCK:   if (lock_ok)    begin state_d = ST_STABLE; xfer = 1'b1; end
                           else if (stage_tmo_hit) take_retry = 1'b1;
                ST_STABLE: if (err_req) begin
                               state_d = ST_RECOV;
                               xfer    = 1'b1;
                               inc_vec[CI_RECOV] = 1'b1;
                           end
                ST_RECOV:  if (lock_ok) begin
                               state_d = ST_STABLE;
                               xfer    = 1'b1;
                           end else if (stage_tmo_hit) begin
                               state_d = ST_DETECT;  // retrain gate
                               xfer    = 1'b1;
                               inc_vec[CI_RETRN] = 1'b1;
                           end
                ST_FAILED: state_d = ST_FAILED;
            endcase
            if (take_retry) begin
                xfer              = 1'b1;
                inc_vec[CI_RETRY] = 1'b1;
                state_d = (retry_cnt >= cfg_retry_limit) ? ST_FAILED : ST_DETECT;
            end
        end
    end

    // state register, stage timer and timebase
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RESET;
            tmr_q   <= '0;
            ts_q    <= '0;
        end else begin
            state_q <= state_d;
            ts_q    <= ts_q + TS_W'(1);
            if (xfer)               tmr_q <= '0;
            else if (tmr_q != '1)   tmr_q <= tmr_q + TMO_W'(1);
        end
    end

    // outputs
    always_comb begin
        state_o        = state_q;
        link_ready     = (state_q == ST_STABLE);
        bringup_failed = (state_q == ST_FAILED);
        retry_cnt      = cnt_arr[CI_RETRY];
        retrain_cnt    = cnt_arr[CI_RETRN];
        recov_cnt      = cnt_arr[CI_RECOV];
    end

    for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
        lt_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clear),
            .inc   (inc_vec[gi]),
            .q     (cnt_arr[gi])
        );
    end

    assign evt_word = {state_d, ts_q};

    logic [EVT_W-1:0] evt_head;
    lt_event_fifo #(.DW(EVT_W), .DEPTH(FIFO_DEPTH)) u_events (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_ovf (cnt_clear),
        .push    (xfer),
        .din     (evt_word),
        .pop     (evt_pop),
        .valid   (evt_valid),
        .dout    (evt_head),
        .ovf     (evt_overflow)
    );
    assign evt_state = evt_head[EVT_W-1 -: 3];
    assign evt_time  = evt_head[TS_W-1:0];

    // R12: software reset overrides everything
    assert_sw_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> state_q == ST_RESET);
    // R6: Failed is held until software reset
    assert_failed_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FAILED && !sw_reset) |=> state_q == ST_FAILED);
    // R3: a low presence sample cannot advance Detect
    assert_debounce_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DETECT && !lane_detect) |=> state_q != ST_TRAIN);
    // R2: Stable is reached only from Lock or Recovery
    assert_stable_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_LOCK && state_q != ST_RECOV && state_q != ST_STABLE)
        |=> state_q != ST_STABLE);
    // R7: recovery entries counted only from Stable
    assert_recov_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STABLE && !cnt_clear) |=> recov_cnt == $past(recov_cnt));
    // R8: retrain gate counted only from Recovery
    assert_retrain_src_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_RECOV && !cnt_clear) |=> retrain_cnt == $past(retrain_cnt));
    // R10: every state change leaves an event queued
    assert_event_logged_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != $past(state_q)) |-> evt_valid);
endmodule

// File: tb/tb_link_train_monitor.sv
module tb_link_train_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_reset = 0, cnt_clear = 0, bringup_en = 0;
    logic        lane_detect = 0, train_done = 0, eq_done = 0, lock_ok = 0, err_req = 0;
    logic [15:0] cfg_detect_tmo = 16'd20, cfg_train_tmo = 16'd10, cfg_stage_tmo = 16'd8;
    logic [7:0]  cfg_debounce = 8'd3;
    logic [3:0]  cfg_retry_limit = 4'd2;
    logic [2:0]  state_o;
    logic        link_ready, bringup_failed;
    logic [3:0]  retry_cnt, retrain_cnt, recov_cnt;
    logic        evt_pop = 0;
    logic        evt_valid, evt_overflow;
    logic [2:0]  evt_state;
    logic [15:0] evt_time;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    link_train_monitor #(.CNT_W(4)) dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cnt_clear(cnt_clear),
        .bringup_en(bringup_en), .lane_detect(lane_detect), .train_done(train_done),
        .eq_done(eq_done), .lock_ok(lock_ok), .err_req(err_req),
        .cfg_detect_tmo(cfg_detect_tmo), .cfg_train_tmo(cfg_train_tmo),
        .cfg_stage_tmo(cfg_stage_tmo), .cfg_debounce(cfg_debounce),
        .cfg_retry_limit(cfg_retry_limit), .state_o(state_o), .link_ready(link_ready),
        .bringup_failed(bringup_failed), .retry_cnt(retry_cnt), .retrain_cnt(retrain_cnt),
        .recov_cnt(recov_cnt), .evt_pop(evt_pop), .evt_valid(evt_valid),
        .evt_state(evt_state), .evt_time(evt_time), .evt_overflow(evt_overflow)
    );

    // rows: {en, lane, train, eq, lock, err, expected state after the edge}
    localparam logic [8:0] VEC [15] = '{
        9'b100000_001, 9'b010000_001, 9'b000000_001, 9'b010000_001,
        9'b010000_001, 9'b010000_010, 9'b000001_010, 9'b001000_011,
        9'b000010_011, 9'b000100_100, 9'b000010_101, 9'b000000_101,
        9'b000001_110, 9'b000000_110, 9'b000010_101
    };

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pop_expect(input int code, input string req, output int t);
        chk(evt_valid == 1'b1, {req, " event queued"}, evt_valid, 1);
        chk(evt_state == code[2:0], {req, " event state"}, evt_state, code);
        t = evt_time;
        evt_pop = 1'b1;
        tick();
        evt_pop = 1'b0;
    endtask

    task automatic drive_all(input logic v);
        lane_detect = v; train_done = v; eq_done = v; lock_ok = v; err_req = v; bringup_en = v;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int t0, t1, t2;
        repeat (3) tick();
        // R1: reset state
        chk(state_o == 3'd0, "R1 state in reset", state_o, 0);
        chk(link_ready == 0 && bringup_failed == 0, "R1 flags in reset", link_ready, 0);
        chk(retry_cnt == 0 && retrain_cnt == 0 && recov_cnt == 0, "R1 counters", recov_cnt, 0);
        chk(evt_valid == 0 && evt_overflow == 0, "R1 event queue empty", evt_valid, 0);
        rst_n = 1'b1;
        tick();
        chk(state_o == 3'd0, "R1 holds Reset without bringup_en", state_o, 0);

        // table walk: R2 order, R3 debounce restart, R7 err ignored outside Stable
        for (int i = 0; i < 15; i++) begin
            {bringup_en, lane_detect, train_done, eq_done, lock_ok, err_req} = VEC[i][8:3];
            tick();
            chk(state_o == VEC[i][2:0], $sformatf("R2 R3 R7 table row %0d state", i),
                state_o, VEC[i][2:0]);
            chk(link_ready == (VEC[i][2:0] == 3'd5), $sformatf("R2 ready row %0d", i),
                link_ready, (VEC[i][2:0] == 3'd5));
        end
        drive_all(1'b0);
        chk(recov_cnt == 1, "R7 recovery entry counted", recov_cnt, 1);
        chk(retry_cnt == 0, "R5 no retries on clean bring-up", retry_cnt, 0);
        chk(evt_overflow == 1, "R11 overflow after seven events", evt_overflow, 1);

        // R10/R11: first four events kept in order with cycle spacing
        pop_expect(1, "R11 head Detect", t0);
        pop_expect(2, "R11 second Train", t1);
        chk(t1 - t0 == 5, "R10 Detect dwell timestamp delta", t1 - t0, 5);
        pop_expect(3, "R11 third Equalize", t0);
        chk(t0 - t1 == 2, "R10 Train dwell timestamp delta", t0 - t1, 2);
        pop_expect(4, "R11 fourth Lock", t1);
        chk(t1 - t0 == 2, "R10 Equalize dwell timestamp delta", t1 - t0, 2);
        chk(evt_valid == 0, "R11 queue drained", evt_valid, 0);

        // R9: clear
        cnt_clear = 1'b1; tick(); cnt_clear = 1'b0;
        chk(recov_cnt == 0, "R9 clear counters", recov_cnt, 0);
        chk(evt_overflow == 0, "R9 clear overflow", evt_overflow, 1'b0);

        // R8: recovery timeout through the retrain gate
        err_req = 1'b1; tick(); err_req = 1'b0;
        chk(state_o == 3'd6 && recov_cnt == 1, "R7 Stable to Recovery", state_o, 6);
        repeat (7) tick();
        chk(state_o == 3'd6, "R4 Recovery held limit-1 cycles", state_o, 6);
        tick();
        chk(state_o == 3'd1, "R8 Recovery timeout to Detect", state_o, 1);
        chk(retrain_cnt == 1, "R8 retrain counted", retrain_cnt, 1);
        chk(retry_cnt == 0, "R8 retry untouched by retrain", retry_cnt, 0);
        pop_expect(6, "R10 Recovery event", t0);
        pop_expect(1, "R10 Detect event", t1);
        chk(t1 - t0 == 8, "R10 Recovery dwell delta", t1 - t0, 8);

        // R4/R5: Detect timeout (two ticks already spent popping)
        repeat (17) tick();
        chk(state_o == 3'd1 && retry_cnt == 0, "R4 Detect before limit", retry_cnt, 0);
        tick();
        chk(state_o == 3'd1 && retry_cnt == 1, "R5 Detect timeout retry", retry_cnt, 1);
        lane_detect = 1'b1; repeat (3) tick(); lane_detect = 1'b0;
        chk(state_o == 3'd2, "R3 debounce reached", state_o, 2);
        repeat (10) tick();
        chk(state_o == 3'd1 && retry_cnt == 2, "R5 Train timeout retry", retry_cnt, 2);
        repeat (20) tick();
        chk(state_o == 3'd7, "R6 budget exceeded enters Failed", state_o, 7);
        chk(bringup_failed == 1 && retry_cnt == 3, "R6 failed flag and count", retry_cnt, 3);
        drive_all(1'b1); repeat (5) tick(); drive_all(1'b0);
        chk(state_o == 3'd7, "R6 Failed holds under strobes", state_o, 7);
        chk(evt_overflow == 0, "R11 exactly full is no overflow", evt_overflow, 0);
        pop_expect(1, "R10 Detect re-entry event", t0);
        pop_expect(2, "R11 Train event", t0);
        pop_expect(1, "R11 Detect event", t0);
        pop_expect(7, "R11 Failed event", t0);

        // R12: software reset
        sw_reset = 1'b1; tick(); sw_reset = 1'b0;
        chk(state_o == 3'd0 && bringup_failed == 0, "R12 sw_reset to Reset", state_o, 0);
        chk(retry_cnt == 3, "R9 sw_reset keeps counters", retry_cnt, 3);
        pop_expect(0, "R10 Reset event", t0);

        // R4: done in last cycle beats timeout
        cnt_clear = 1'b1; bringup_en = 1'b1; tick(); cnt_clear = 1'b0; bringup_en = 1'b0;
        chk(state_o == 3'd1 && retry_cnt == 0, "R1 enable leaves Reset", state_o, 1);
        lane_detect = 1'b1; repeat (3) tick(); lane_detect = 1'b0;
        repeat (9) tick();
        train_done = 1'b1; tick(); train_done = 1'b0;
        chk(state_o == 3'd3 && retry_cnt == 0, "R4 done wins on last cycle", state_o, 3);

        // R9: saturation
        eq_done = 1'b1; tick(); eq_done = 1'b0;
        lock_ok = 1'b1; tick(); lock_ok = 1'b0;
        chk(link_ready == 1, "R2 Stable after lock", link_ready, 1);
        for (int k = 0; k < 17; k++) begin
            err_req = 1'b1; tick(); err_req = 1'b0;
            lock_ok = 1'b1; tick(); lock_ok = 1'b0;
        end
        chk(recov_cnt == 15, "R9 recovery count saturates", recov_cnt, 15);
        chk(state_o == 3'd5, "R8 relock returns to Stable", state_o, 5);
        chk(evt_overflow == 1, "R11 overflow sticky", evt_overflow, 1);

        // R12: priority over err_req
        err_req = 1'b1; sw_reset = 1'b1; tick(); err_req = 1'b0; sw_reset = 1'b0;
        chk(state_o == 3'd0, "R12 sw_reset beats err_req", state_o, 0);

        // R4: limit 0 disables the Detect timeout
        cfg_detect_tmo = 16'd0;
        cnt_clear = 1'b1; bringup_en = 1'b1; tick(); cnt_clear = 1'b0; bringup_en = 1'b0;
        repeat (100) tick();
        chk(state_o == 3'd1 && retry_cnt == 0, "R4 zero limit never times out", retry_cnt, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule